// File: doc/BRIEF.md
# Asynchronous Memory Read Strobe Sequencer

This block runs one read access to an asynchronous external memory. It produces an active-low chip-enable strobe and an active-low output-enable (read) strobe. It drives the address and byte-select lines and latches the word the memory returns. Each strobe has its own programmable timing, counted in whole cycles of the system clock:

- a lead-in (setup) count,
- an active (pulse) count,
- a total-cycle count.

The idle tail of each strobe, its hold, is whatever is left of its cycle after setup and pulse. A mode input chooses which strobe's rising edge latches the data.

A requester presents a request together with an address, byte selects and the timing settings. The block acknowledges in the same cycle if it is idle and the settings are legal. It then runs the access for as many cycles as the longer of the two total-cycle counts. A one-cycle completion pulse marks the last cycle, and the captured word is available from the next cycle. An illegal setting is refused: no access starts and an error flag is raised.

Top module: `memRdSeq`

## Requirements
- R1: After reset both strobes are high (inactive), and `doneP`, `cfgErr` and `rdData` are 0.
- R2: Access cycles are numbered from 0, where cycle 0 is the cycle after the clock edge at which `reqAck` was high. `memCsN` is low exactly in cycles c with csSetup <= c < csSetup+csPulse, and high in every other cycle.
- R3: `memRdN` is low exactly in cycles c with rdSetup <= c < rdSetup+rdPulse, and high in every other cycle.
- R4: The access lasts max(csCycle, rdCycle) cycles. `doneP` is high only in the last of these cycles. Both strobes are high whenever no access is running.
- R5: With `modeRd`=1, `rdData` takes the `memData` value present in cycle rdSetup+rdPulse-1, the last low cycle of `memRdN`. `rdData` is valid from the cycle after `doneP`.
- R6: With `modeRd`=0, `rdData` takes the `memData` value present in cycle csSetup+csPulse-1, the last low cycle of `memCsN`.
- R7: `memAddr` and `memBsel` take `reqAddr` and `reqBsel` at the accepting edge. They stay constant throughout the access.
- R8: A setting is legal when both pulse counts are at least 1 and each cycle count is at least its setup plus pulse count. An illegal request gets no `reqAck` and starts no access, and `cfgErr` is high in the following cycle.
- R9: `reqAck` is high only while the block is idle. With `reqValid` held high, the next request is acknowledged in the cycle right after `doneP`.
- R10: The timing settings and mode are sampled at acceptance. Changing them during an access has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing counts are in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request |
| reqAddr | input | ADDR_W | Address of the read |
| reqBsel | input | BSEL_W | Byte selects of the read |
| reqAck | output | 1 | Request accepted this cycle |
| csSetup | input | CNT_W | Chip-enable lead-in cycles |
| csPulse | input | CNT_W | Chip-enable active cycles |
| csCycle | input | CNT_W | Chip-enable total cycles |
| rdSetup | input | CNT_W | Read-strobe lead-in cycles |
| rdPulse | input | CNT_W | Read-strobe active cycles |
| rdCycle | input | CNT_W | Read-strobe total cycles |
| modeRd | input | 1 | 1: latch on read-strobe rise; 0: latch on chip-enable rise |
| cfgErr | output | 1 | Previous cycle saw a request with an illegal setting |
| memCsN | output | 1 | Chip-enable strobe, active low |
| memRdN | output | 1 | Read strobe, active low |
| memAddr | output | ADDR_W | Address to the memory |
| memBsel | output | BSEL_W | Byte selects to the memory |
| memData | input | DATA_W | Data from the memory |
| doneP | output | 1 | High in the last cycle of an access |
| rdData | output | DATA_W | Latched read word |

## Verification
Five timing sets are applied, each with its own mix of setups, pulses and cycle counts:

- One set has every count at its minimum.
- In some sets the chip-enable cycle is longer; in others the read-strobe cycle is.
- Two sets use the same timings in both latch modes.

The memory returns a different word in each cycle, so the latched word shows which cycle was sampled. That separates the two latch modes and exposes any off-by-one in the capture point. Recording the whole per-cycle strobe waveform also tells a mis-placed edge apart from a wrong access length. Directed cases cover illegal settings, a back-to-back request held high, and settings changed part-way through an access.

// File: rtl/memRdPkg.sv
package memRdPkg;
  // strobes from sequencing control to the address/data path
  typedef struct packed {
    logic load;     // take request address and byte selects
    logic capture;  // latch memory data at this edge
  } pathCtl_t;
endpackage

// File: rtl/memRdStrobe.sv
module memRdStrobe #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             advance,
  input  logic [CNT_W-1:0] nextCnt,
  input  logic [CNT_W-1:0] setupIn,
  input  logic [CNT_W-1:0] pulseIn,
  input  logic [CNT_W-1:0] cycleIn,
  output logic             strbN,
  output logic             riseNow,
  output logic             cfgOk
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] sSet, selSet;
  logic [SUM_W-1:0] sEnd, selEnd, endIn;
  logic             lowNext;

  assign endIn  = SUM_W'(setupIn) + SUM_W'(pulseIn);
  assign cfgOk  = (pulseIn != '0) && (SUM_W'(cycleIn) >= endIn);
  assign selSet = load ? setupIn : sSet;
  assign selEnd = load ? endIn : sEnd;

  always_comb begin
    lowNext = 1'b0;
    if (load || advance)
      lowNext = (nextCnt >= selSet) && (SUM_W'(nextCnt) < selEnd);
  end

  // strobe is low now and goes high at the coming edge
  assign riseNow = !strbN && !lowNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strbN <= 1'b1;
      sSet  <= '0;
      sEnd  <= '0;
    end else begin
      strbN <= !lowNext;
      if (load) begin
        sSet <= setupIn;
        sEnd <= endIn;
      end
    end
  end
endmodule

// File: rtl/memRdCtrl.sv
module memRdCtrl
  import memRdPkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] csSetup,
  input  logic [CNT_W-1:0] csPulse,
  input  logic [CNT_W-1:0] csCycle,
  input  logic [CNT_W-1:0] rdSetup,
  input  logic [CNT_W-1:0] rdPulse,
  input  logic [CNT_W-1:0] rdCycle,
  input  logic             modeRd,
  output logic             reqAck,
  output logic             memCsN,
  output logic             memRdN,
  output logic             doneP,
  output logic             cfgErr,
  output logic             busy,
  output pathCtl_t         ctl
);
  localparam int NSTRB = 2;  // index 0: chip enable, 1: read strobe

  logic [CNT_W-1:0] cnt, sLast, nextCnt, lastIn;
  logic             sMode, accept, advance, allOk;
  logic [NSTRB-1:0] okVec, strbN, riseVec;
  logic [CNT_W-1:0] setArr [NSTRB];
  logic [CNT_W-1:0] pulArr [NSTRB];
  logic [CNT_W-1:0] cycArr [NSTRB];

  assign setArr[0] = csSetup;
  assign pulArr[0] = csPulse;
  assign cycArr[0] = csCycle;
  assign setArr[1] = rdSetup;
  assign pulArr[1] = rdPulse;
  assign cycArr[1] = rdCycle;

  assign allOk   = &okVec;
  assign accept  = reqValid && !busy && allOk;
  assign reqAck  = accept;
  assign advance = busy && (cnt != sLast);
  assign nextCnt = accept ? '0 : cnt + CNT_W'(1);
  assign lastIn  = ((csCycle >= rdCycle) ? csCycle : rdCycle) - CNT_W'(1);
  assign doneP   = busy && (cnt == sLast);

  for (genvar g = 0; g < NSTRB; g++) begin : gStrb
    memRdStrobe #(.CNT_W(CNT_W)) uStrb (
      .clk     (clk),
      .rstN    (rstN),
      .load    (accept),
      .advance (advance),
      .nextCnt (nextCnt),
      .setupIn (setArr[g]),
      .pulseIn (pulArr[g]),
      .cycleIn (cycArr[g]),
      .strbN   (strbN[g]),
      .riseNow (riseVec[g]),
      .cfgOk   (okVec[g])
    );
  end

  assign memCsN      = strbN[0];
  assign memRdN      = strbN[1];
  assign ctl.load    = accept;
  assign ctl.capture = busy && (sMode ? riseVec[1] : riseVec[0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      sLast  <= '0;
      sMode  <= 1'b0;
      cfgErr <= 1'b0;
    end else begin
      cfgErr <= reqValid && !busy && !allOk;
      if (accept) begin
        busy  <= 1'b1;
        sLast <= lastIn;
        sMode <= modeRd;
      end else if (doneP) begin
        busy <= 1'b0;
      end
      if (accept || advance) cnt <= nextCnt;
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memCsN && memRdN)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> (!doneP && !busy)); // R4
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !busy); // R8
  AST_ACK_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> (busy && cnt == '0)); // R9
endmodule

// File: rtl/memRdPath.sv
module memRdPath
  import memRdPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BSEL_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BSEL_W-1:0] reqBsel,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BSEL_W-1:0] memBsel,
  output logic [DATA_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      memBsel <= '0;
      rdData  <= '0;
    end else begin
      if (ctl.load) begin
        memAddr <= reqAddr;
        memBsel <= reqBsel;
      end
      if (ctl.capture) rdData <= memData;
    end
  end

  AST_NO_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |-> !ctl.capture); // R7
endmodule

// File: rtl/memRdSeq.sv
module memRdSeq
  import memRdPkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int ADDR_W = 24,
  parameter int BSEL_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BSEL_W-1:0] reqBsel,
  output logic              reqAck,
  input  logic [CNT_W-1:0]  csSetup,
  input  logic [CNT_W-1:0]  csPulse,
  input  logic [CNT_W-1:0]  csCycle,
  input  logic [CNT_W-1:0]  rdSetup,
  input  logic [CNT_W-1:0]  rdPulse,
  input  logic [CNT_W-1:0]  rdCycle,
  input  logic              modeRd,
  output logic              cfgErr,
  output logic              memCsN,
  output logic              memRdN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BSEL_W-1:0] memBsel,
  input  logic [DATA_W-1:0] memData,
  output logic              doneP,
  output logic [DATA_W-1:0] rdData
);
  pathCtl_t ctl;
  logic     busy;

  memRdCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .csSetup(csSetup), .csPulse(csPulse), .csCycle(csCycle),
    .rdSetup(rdSetup), .rdPulse(rdPulse), .rdCycle(rdCycle),
    .modeRd(modeRd), .reqAck(reqAck), .memCsN(memCsN), .memRdN(memRdN),
    .doneP(doneP), .cfgErr(cfgErr), .busy(busy), .ctl(ctl)
  );

  memRdPath #(.ADDR_W(ADDR_W), .BSEL_W(BSEL_W), .DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqBsel(reqBsel),
    .memData(memData), .memAddr(memAddr), .memBsel(memBsel), .rdData(rdData)
  );

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(memAddr) && $stable(memBsel))); // R7
endmodule

// File: tb/sim_memRdSeq.sv
`timescale 1ns/1ps
module sim_memRdSeq;
  localparam int CNT_W = 6, ADDR_W = 24, BSEL_W = 2, DATA_W = 16;
  localparam int NVEC = 5;
  // csSetup, csPulse, csCycle, rdSetup, rdPulse, rdCycle, modeRd
  localparam int VEC [0:NVEC-1][0:6] = '{
    '{0, 1, 1, 0, 1, 1, 1},
    '{0, 5, 7, 1, 2, 4, 1},
    '{0, 5, 7, 1, 2, 4, 0},
    '{2, 2, 4, 0, 3, 8, 1},
    '{3, 1, 4, 1, 1, 9, 0}
  };

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0, modeRd = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0, memAddr;
  logic [BSEL_W-1:0] reqBsel = '0, memBsel;
  logic [CNT_W-1:0]  csSetup = '0, csPulse = '0, csCycle = '0;
  logic [CNT_W-1:0]  rdSetup = '0, rdPulse = '0, rdCycle = '0;
  logic [DATA_W-1:0] memData = '0, rdData;
  logic reqAck, cfgErr, memCsN, memRdN, doneP;
  int testCnt = 0, failCnt = 0;

  always #2 clk = ~clk;

  memRdSeq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BSEL_W(BSEL_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqBsel(reqBsel),
    .reqAck(reqAck), .csSetup(csSetup), .csPulse(csPulse), .csCycle(csCycle),
    .rdSetup(rdSetup), .rdPulse(rdPulse), .rdCycle(rdCycle), .modeRd(modeRd),
    .cfgErr(cfgErr), .memCsN(memCsN), .memRdN(memRdN), .memAddr(memAddr),
    .memBsel(memBsel), .memData(memData), .doneP(doneP), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int a, b, c, d, e, f, m);
    csSetup = CNT_W'(a); csPulse = CNT_W'(b); csCycle = CNT_W'(c);
    rdSetup = CNT_W'(d); rdPulse = CNT_W'(e); rdCycle = CNT_W'(f);
    modeRd  = m[0];
  endtask

  // one full read; expected values follow R2..R7 and R10
  task automatic doRead(input int cs, cp, cc, rs, rp, rc, md,
                        input logic [ADDR_W-1:0] addr, input bit scramble);
    logic [63:0] csW = '1, rdW = '1, csE = '1, rdE = '1;
    int len = 0, total, k;
    bit addrOk = 1'b1, fin = 1'b0;
    @(negedge clk);
    setCfg(cs, cp, cc, rs, rp, rc, md);
    reqAddr = addr; reqBsel = addr[BSEL_W-1:0]; reqValid = 1'b1;
    #1 check(reqAck == 1'b1, "R9", "ack when idle", reqAck, 1);
    @(posedge clk);
    for (int c = 0; c < 64 && !fin; c++) begin
      @(negedge clk);
      if (c == 0) begin
        reqValid = 1'b0;
        reqAddr = ~addr;
        if (scramble) setCfg(2, 3, 9, 4, 4, 12, md ^ 1);
      end
      memData = DATA_W'(16'hA000 + c);
      #1;
      csW[c] = memCsN; rdW[c] = memRdN;
      if (memAddr != addr || memBsel != addr[BSEL_W-1:0]) addrOk = 1'b0;
      if (doneP) begin len = c + 1; fin = 1'b1; end
    end
    total = (cc > rc) ? cc : rc;
    for (int c = 0; c < total; c++) begin
      csE[c] = !(c >= cs && c < cs + cp);
      rdE[c] = !(c >= rs && c < rs + rp);
    end
    k = md ? (rs + rp - 1) : (cs + cp - 1);
    check(len == total, "R4", "access length", len, total);
    check(csW == csE, "R2", "chip-enable waveform", csW, csE);
    check(rdW == rdE, "R3", "read-strobe waveform", rdW, rdE);
    check(addrOk, "R7", "address held", memAddr, addr);
    @(negedge clk);
    check(rdData == DATA_W'(16'hA000 + k), md ? "R5" : "R6", "captured word",
          rdData, 16'hA000 + k);
    check(memCsN && memRdN, "R4", "strobes high after", {memCsN, memRdN}, 3);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog all requirements actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(memCsN && memRdN && !doneP && !cfgErr && rdData == '0, "R1",
          "reset state", {memCsN, memRdN, doneP, cfgErr}, 4'b1100);
    rstN = 1'b1;

    // table of timing sets
    for (int v = 0; v < NVEC; v++)
      doRead(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
             VEC[v][5], VEC[v][6], ADDR_W'(24'h10_0000 + v * 24'h111), 1'b0);

    // R10: settings changed mid-access are ignored
    doRead(1, 2, 5, 0, 3, 3, 1, 24'hABCDEF, 1'b1);

    // R8: zero pulse is illegal
    @(negedge clk);
    setCfg(1, 0, 4, 0, 2, 3, 1); reqValid = 1'b1;
    #1 check(!reqAck, "R8", "no ack zero pulse", reqAck, 0);
    @(negedge clk);
    check(cfgErr && memCsN && memRdN, "R8", "err flag, no access",
          {cfgErr, memCsN, memRdN}, 3'b111);
    // R8: cycle shorter than setup plus pulse is illegal
    setCfg(0, 1, 2, 2, 3, 4, 0);
    #1 check(!reqAck, "R8", "no ack short cycle", reqAck, 0);
    @(negedge clk);
    check(cfgErr && memCsN && memRdN, "R8", "err flag short cycle",
          {cfgErr, memCsN, memRdN}, 3'b111);
    reqValid = 1'b0;
    @(negedge clk);
    check(!cfgErr, "R8", "err clears", cfgErr, 0);

    // R9: request held high, next ack right after done
    setCfg(0, 2, 3, 1, 1, 2, 1); reqValid = 1'b1;
    #1 check(reqAck, "R9", "first ack", reqAck, 1);
    for (int s = 1; s <= 3; s++) begin
      @(negedge clk);
      #1 check(!reqAck, "R9", "no ack while busy", reqAck, 0);
      if (s == 3) check(doneP, "R4", "done in last cycle", doneP, 1);
    end
    @(negedge clk);
    #1 check(reqAck && !doneP, "R9", "ack after done", {reqAck, doneP}, 2'b10);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule